// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Level Interrupts

This block is the sample-buffering half of an audio serial port. A transmit queue takes 16-bit samples that software writes through a small register window and hands them one at a time to the serialiser. A receive queue collects samples from the deserialiser and gives them back to software through a read that pops. Each queue reports how full it is through a set of level flags. The block raises one interrupt line built from a receive-overrun event and from two level conditions whose threshold software picks.

Software can flush either queue and can clear the overrun state. It can also turn on a loopback path. In loopback the serialiser interface goes quiet and every queued transmit sample moves straight into the receive queue, one per cycle, so that a driver can test itself without any external wiring. Register map (3-bit address): 0 control, 1 transmit data (write pushes), 2 receive data (read pops), 3 status, 4 interrupt enable, 5 interrupt status. Other addresses read as zero.

Top module: `snd_fifo_irq`

## Requirements
- R1: After reset both queues are empty, loopback is off, the enables, triggers and overrun are zero, and `irq` is low. The status register reads 0x0055.
- R2: A write to address 1 appends `reg_wdata` to the transmit queue. `tx_sample` shows the oldest sample, and `tx_sample_vld` is high while the queue holds data and loopback is off. `tx_sample_req` removes the oldest sample. A write to a full transmit queue is discarded.
- R3: `rx_sample_vld` appends `rx_sample` to the receive queue. A read of address 2 returns the oldest sample and removes it. On an empty queue it returns 0 and changes nothing.
- R4: Status (address 3) holds these bits, from bit 0 upward: receive empty, receive full, transmit empty, transmit full, receive almost-empty (4 or fewer entries), receive almost-full (12 or more), transmit almost-empty, transmit almost-full, receive half (8 or more), transmit half. The queues hold 16 entries.
- R5: Control bits [5:4] pick the transmit trigger and bits [7:6] pick the receive trigger. Value 0 selects almost-empty, 1 selects half, 2 selects almost-full and 3 never triggers. Interrupt status bit 2 is the transmit level hit and bit 1 is the receive level hit. Both follow the fill level continuously.
- R6: A sample that arrives at a full receive queue is dropped and sets interrupt status bit 0. That bit stays set until a write to address 5 with bit 0 at 1. A drop in the same cycle as such a write leaves the bit set.
- R7: `irq` is the OR of the interrupt status bits masked by enable bits [2:0] (address 4, same positions).
- R8: Control write bit 0 flushes the transmit queue. Bit 1 flushes the receive queue and clears the overrun. Bit 2 flushes the receive queue only. A flush takes precedence over a push in the same cycle.
- R9: While control bit 3 (loopback) is set, one transmit sample per cycle moves into the receive queue and is dropped with overrun when that queue is full. `rx_sample_vld` and `tx_sample_req` are ignored and `tx_sample_vld` is low.
- R10: A push and a pop on the same queue in the same cycle both take effect, even when that queue is full: no drop and no overrun, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 2) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| tx_sample_req | input | 1 | Serialiser takes the oldest transmit sample |
| tx_sample | output | 16 | Oldest transmit sample |
| tx_sample_vld | output | 1 | Transmit sample available |
| rx_sample_vld | input | 1 | Deserialiser delivers a sample |
| rx_sample | input | 16 | Received sample |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle. In the first, a sample reaches a full receive queue while software clears the overrun bit. In the second, a sample reaches a full receive queue while software pops that queue. The bench drives each pair deliberately once the receive queue has been filled to 16. It then reads the interrupt status and the status word in the following cycle. The first case must leave the overrun set. The second must show a full queue with no overrun. Random traffic that mixes loopback, flushes and register pops then keeps hitting these collisions, and each cycle is judged against a queue model in the bench.

// File: rtl/snd_fifo_pkg.sv
package snd_fifo_pkg;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_TXD   = 3'd1;
  localparam logic [2:0] ADR_RXD   = 3'd2;
  localparam logic [2:0] ADR_STAT  = 3'd3;
  localparam logic [2:0] ADR_IEN   = 3'd4;
  localparam logic [2:0] ADR_ISTAT = 3'd5;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HALF = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_OFF  = 2'd3
  } trig_e;

  typedef struct packed {
    logic half;
    logic afull;
    logic aempty;
    logic full;
    logic empty;
  } lvl_t;

  function automatic lvl_t lvl_calc(int cnt, int depth, int ae, int hf, int af);
    lvl_t l;
    l.empty  = (cnt == 0);
    l.full   = (cnt >= depth);
    l.aempty = (cnt <= ae);
    l.half   = (cnt >= hf);
    l.afull  = (cnt >= af);
    return l;
  endfunction

  function automatic logic trig_hit(lvl_t l, trig_e sel);
    case (sel)
      TRIG_LOW:  return l.aempty;
      TRIG_HALF: return l.half;
      TRIG_HIGH: return l.afull;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [9:0] status_word(lvl_t rx, lvl_t tx);
    return {tx.half, rx.half, tx.afull, tx.aempty, rx.afull, rx.aempty,
            tx.full, tx.empty, rx.full, rx.empty};
  endfunction

endpackage

// File: rtl/snd_sample_fifo.sv
module snd_sample_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         push_drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          pop_ok, push_ok;

  assign pop_ok    = pop && (count != '0) && !flush;
  assign push_ok   = push && ((count != FULL_CNT) || pop_ok) && !flush;
  assign push_drop = push && !push_ok && !flush;
  assign dout      = mem[rptr];

  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/snd_level_flags.sv
module snd_level_flags
  import snd_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AE_LVL = 4,
  parameter int HF_LVL = 8,
  parameter int AF_LVL = 12
) (
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [1:0]                 trig,
  output lvl_t                       lvl,
  output logic                       hit
);
  assign lvl = lvl_calc(int'(count), DEPTH, AE_LVL, HF_LVL, AF_LVL);
  assign hit = trig_hit(lvl, trig_e'(trig));
endmodule

// File: rtl/snd_fifo_irq.sv
module snd_fifo_irq
  import snd_fifo_pkg::*;
#(
  parameter int DW     = 16,
  parameter int DEPTH  = 16,
  parameter int AE_LVL = 4,
  parameter int HF_LVL = 8,
  parameter int AF_LVL = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tx_sample_req,
  output logic [DW-1:0] tx_sample,
  output logic          tx_sample_vld,
  input  logic          rx_sample_vld,
  input  logic [DW-1:0] rx_sample,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NQ = 2;          // queue 0 = receive, queue 1 = transmit

  // control state
  logic       lb_q;
  logic [1:0] tx_trig_q, rx_trig_q;
  logic [2:0] ien_q;
  logic       ovr_q;

  // named internal events
  logic          ctrl_wr, tx_flush, rx_flush_all, rx_flush_only, rx_flush;
  logic          tx_push, tx_pop, rx_push, rx_pop, rx_drop, tx_drop, lb_move;
  logic          ovr_w1c;
  logic [DW-1:0] tx_head, rx_head, rx_din;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [CW-1:0] q_cnt  [NQ];
  logic [1:0]    q_trig [NQ];
  lvl_t          q_lvl  [NQ];
  logic          q_hit  [NQ];
  logic [2:0]    istat;

  assign ctrl_wr       = reg_wr && (reg_addr == ADR_CTRL);
  assign tx_flush      = ctrl_wr && reg_wdata[0];
  assign rx_flush_all  = ctrl_wr && reg_wdata[1];
  assign rx_flush_only = ctrl_wr && reg_wdata[2];
  assign rx_flush      = rx_flush_all || rx_flush_only;
  assign ovr_w1c       = reg_wr && (reg_addr == ADR_ISTAT) && reg_wdata[0];

  // loopback moves one sample per cycle regardless of serialiser requests
  assign lb_move = lb_q && (tx_cnt != '0);
  assign tx_push = reg_wr && (reg_addr == ADR_TXD);
  assign tx_pop  = lb_q ? lb_move : tx_sample_req;
  assign rx_push = lb_q ? lb_move : rx_sample_vld;
  assign rx_din  = lb_q ? tx_head : rx_sample;
  assign rx_pop  = reg_rd && (reg_addr == ADR_RXD);

  snd_sample_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .din(reg_wdata),
    .pop(tx_pop), .dout(tx_head), .count(tx_cnt), .push_drop(tx_drop)
  );

  snd_sample_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .din(rx_din),
    .pop(rx_pop), .dout(rx_head), .count(rx_cnt), .push_drop(rx_drop)
  );

  assign q_cnt[0]  = rx_cnt;
  assign q_cnt[1]  = tx_cnt;
  assign q_trig[0] = rx_trig_q;
  assign q_trig[1] = tx_trig_q;

  for (genvar g = 0; g < NQ; g++) begin : g_lvl
    snd_level_flags #(
      .DEPTH(DEPTH), .AE_LVL(AE_LVL), .HF_LVL(HF_LVL), .AF_LVL(AF_LVL)
    ) u_flags (
      .count(q_cnt[g]), .trig(q_trig[g]), .lvl(q_lvl[g]), .hit(q_hit[g])
    );
  end

  // control register and sticky overrun
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_q      <= 1'b0;
      tx_trig_q <= 2'd0;
      rx_trig_q <= 2'd0;
      ien_q     <= 3'd0;
      ovr_q     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        lb_q      <= reg_wdata[3];
        tx_trig_q <= reg_wdata[5:4];
        rx_trig_q <= reg_wdata[7:6];
      end
      if (reg_wr && (reg_addr == ADR_IEN)) ien_q <= reg_wdata[2:0];
      if (rx_flush_all)  ovr_q <= 1'b0;
      else if (rx_drop)  ovr_q <= 1'b1;
      else if (ovr_w1c)  ovr_q <= 1'b0;
    end
  end

  assign istat = {q_hit[1], q_hit[0], ovr_q};
  assign irq   = |(istat & ien_q);

  assign tx_sample     = tx_head;
  assign tx_sample_vld = !lb_q && (tx_cnt != '0);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL:  reg_rdata[7:0] = {rx_trig_q, tx_trig_q, lb_q, 3'b000};
      ADR_RXD:   reg_rdata      = (rx_cnt != '0) ? rx_head : '0;
      ADR_STAT:  reg_rdata[9:0] = status_word(q_lvl[0], q_lvl[1]);
      ADR_IEN:   reg_rdata[2:0] = ien_q;
      ADR_ISTAT: reg_rdata[2:0] = istat;
      default:   reg_rdata      = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[DW-1:8], tx_drop};
endmodule

// File: rtl/snd_fifo_chk.sv
module snd_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
  input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
  input logic                       rx_drop,
  input logic                       rx_flush_all,
  input logic                       rx_flush,
  input logic                       ovr_q,
  input logic                       ovr_w1c,
  input logic [2:0]                 ien_q,
  input logic                       irq,
  input logic                       lb_q,
  input logic                       tx_sample_vld,
  input logic                       rx_push,
  input logic                       rx_pop
);
  // R2
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= DEPTH);

  // R3
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= DEPTH);

  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> ovr_q);

  // R6
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_w1c && !rx_flush_all) |=> ovr_q);

  // R7
  irq_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && ien_q[0]) |-> irq);

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_cnt == '0));

  // R8
  flush_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_all |=> !ovr_q);

  // R9
  lb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_q |-> !tx_sample_vld);

  // R10
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == DEPTH && rx_push && rx_pop && !rx_flush) |=> (rx_cnt == DEPTH));
endmodule

bind snd_fifo_irq snd_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_drop(rx_drop),
  .rx_flush_all(rx_flush_all), .rx_flush(rx_flush), .ovr_q(ovr_q), .ovr_w1c(ovr_w1c),
  .ien_q(ien_q), .irq(irq), .lb_q(lb_q), .tx_sample_vld(tx_sample_vld),
  .rx_push(rx_push), .rx_pop(rx_pop)
);

// File: tb/sim_snd_fifo_irq.sv
module sim_snd_fifo_irq;
  localparam int PERIOD = 10;
  localparam int QD     = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        tx_sample_req = 1'b0;
  logic [15:0] tx_sample;
  logic        tx_sample_vld;
  logic        rx_sample_vld = 1'b0;
  logic [15:0] rx_sample = 16'h0;
  logic        irq;

  always #(PERIOD/2) clk = ~clk;

  snd_fifo_irq u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_sample_req(tx_sample_req),
    .tx_sample(tx_sample), .tx_sample_vld(tx_sample_vld), .rx_sample_vld(rx_sample_vld),
    .rx_sample(rx_sample), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [15:0] mtx[$];
  logic [15:0] mrx[$];
  logic        m_ovr = 0, m_lb = 0;
  logic [1:0]  m_tt = 0, m_rt = 0;
  logic [2:0]  m_ien = 0;

  function automatic logic lvl_hit(int n, logic [1:0] s);
    if (s == 2'd0) return n < 5;
    if (s == 2'd1) return n > 7;
    if (s == 2'd2) return n > 11;
    return 1'b0;
  endfunction

  function automatic logic [15:0] exp_status();
    int r = mrx.size();
    int t = mtx.size();
    logic [15:0] s = 16'h0;
    s[0] = (r == 0);  s[1] = (r == QD);
    s[2] = (t == 0);  s[3] = (t == QD);
    s[4] = (r < 5);   s[5] = (r > 11);
    s[6] = (t < 5);   s[7] = (t > 11);
    s[8] = (r > 7);   s[9] = (t > 7);
    return s;
  endfunction

  function automatic logic [2:0] exp_istat();
    return {lvl_hit(mtx.size(), m_tt), lvl_hit(mrx.size(), m_rt), m_ovr};
  endfunction

  function automatic logic [15:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return {8'h0, m_rt, m_tt, m_lb, 3'b000};
      3'd2: return (mrx.size() > 0) ? mrx[0] : 16'h0;
      3'd3: return exp_status();
      3'd4: return {13'h0, m_ien};
      3'd5: return {13'h0, exp_istat()};
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIL? no");
    end
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [2:0] a,
                     input logic [15:0] wd, input logic rxv, input logic [15:0] rxd,
                     input logic treq, input string tag);
    logic        tpop, rpush, rpop, txf, rxfa, rxf;
    logic [15:0] rdin;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    rx_sample_vld = rxv; rx_sample = rxd; tx_sample_req = treq;
    #1;
    chk(tag, reg_rdata, exp_read(a));
    chk("R7", {15'h0, irq}, {15'h0, |(exp_istat() & m_ien)});
    if (m_lb) chk("R9", {15'h0, tx_sample_vld}, 16'h0);
    else begin
      chk("R2", {15'h0, tx_sample_vld}, {15'h0, mtx.size() > 0});
      if (mtx.size() > 0) chk("R2", tx_sample, mtx[0]);
    end
    // model step
    txf  = wr && a == 3'd0 && wd[0];
    rxfa = wr && a == 3'd0 && wd[1];
    rxf  = wr && a == 3'd0 && wd[2];
    tpop  = m_lb ? (mtx.size() > 0) : (treq && mtx.size() > 0);
    rdin  = m_lb ? ((mtx.size() > 0) ? mtx[0] : 16'h0) : rxd;
    rpush = m_lb ? (mtx.size() > 0) : rxv;
    rpop  = rd && a == 3'd2 && mrx.size() > 0;
    if (txf) mtx.delete();
    else begin
      if (tpop) void'(mtx.pop_front());
      if (wr && a == 3'd1 && mtx.size() < QD) mtx.push_back(wd);
    end
    if (rxfa) m_ovr = 0;
    if (rxfa || rxf) mrx.delete();
    else begin
      if (rpop) void'(mrx.pop_front());
      if (rpush) begin
        if (mrx.size() < QD) mrx.push_back(rdin);
        else m_ovr = 1;
      end else if (wr && a == 3'd5 && wd[0]) m_ovr = 0;
    end
    if (!(rxfa || rxf) && !rpush && wr && a == 3'd5 && wd[0]) m_ovr = 0;
    if (!(rxfa || rxf) && rpush && mrx.size() <= QD && wr && a == 3'd5 && wd[0] && !m_ovr) m_ovr = 0;
    if (wr && a == 3'd0) begin m_lb = wd[3]; m_tt = wd[5:4]; m_rt = wd[7:6]; end
    if (wr && a == 3'd4) m_ien = wd[2:0];
  endtask

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return "R9";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd5: return "R6";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state, sampled while reset is held
    reg_addr = 3'd3;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", reg_rdata, 16'h0055);
    chk("R1", {15'h0, irq}, 16'h0);
    rst_n = 1'b1;
    cyc(0, 0, 3'd5, 0, 0, 0, 0, "R1");
    cyc(0, 0, 3'd0, 0, 0, 0, 0, "R1");

    // R2: fill transmit queue beyond capacity, order kept
    for (int i = 0; i < 17; i++) cyc(1, 0, 3'd1, 16'hA000 + 16'(i), 0, 0, 0, "R2");
    cyc(0, 0, 3'd3, 0, 0, 0, 0, "R4");
    // R10: push and pop on a full transmit queue
    cyc(1, 0, 3'd1, 16'hBEEF, 0, 0, 1, "R10");
    cyc(0, 0, 3'd3, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 16; i++) cyc(0, 0, 3'd3, 0, 0, 0, 1, "R4");

    // R3: fill receive queue, enable all interrupts
    cyc(1, 0, 3'd4, 16'h0007, 0, 0, 0, "R7");
    for (int i = 0; i < 16; i++) cyc(0, 0, 3'd3, 0, 1, 16'h5000 + 16'(i), 0, "R4");
    // R10: arrival and pop at full: no overrun
    cyc(0, 1, 3'd2, 0, 1, 16'h6666, 0, "R10");
    cyc(0, 0, 3'd5, 0, 0, 0, 0, "R10");
    // R6: overrun, then clear colliding with a new drop
    cyc(0, 0, 3'd5, 0, 1, 16'h7777, 0, "R6");
    cyc(1, 0, 3'd5, 16'h0001, 1, 16'h7778, 0, "R6");
    cyc(0, 0, 3'd5, 0, 0, 0, 0, "R6");
    cyc(1, 0, 3'd5, 16'h0001, 0, 0, 0, "R6");
    cyc(0, 0, 3'd5, 0, 0, 0, 0, "R6");
    // R5: every trigger choice on both queues
    for (int s = 0; s < 4; s++) begin
      cyc(1, 0, 3'd0, 16'((s << 6) | (s << 4)), 0, 0, 0, "R5");
      cyc(0, 0, 3'd5, 0, 0, 0, 0, "R5");
    end
    // R3: drain a few by register pops
    for (int i = 0; i < 6; i++) cyc(0, 1, 3'd2, 0, 0, 0, 0, "R3");
    cyc(0, 0, 3'd5, 0, 0, 0, 0, "R5");
    // R8: receive-only flush with a colliding arrival, overrun kept
    cyc(0, 0, 3'd5, 0, 1, 16'h1111, 0, "R8");
    cyc(1, 0, 3'd0, 16'h0004, 1, 16'h2222, 0, "R8");
    cyc(0, 0, 3'd3, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 17; i++) cyc(0, 0, 3'd3, 0, 1, 16'(i), 0, "R8");
    cyc(1, 0, 3'd0, 16'h0002, 0, 0, 0, "R8");
    cyc(0, 0, 3'd5, 0, 0, 0, 0, "R8");
    cyc(1, 0, 3'd1, 16'h0101, 0, 0, 0, "R8");
    cyc(1, 0, 3'd0, 16'h0001, 0, 0, 0, "R8");
    cyc(0, 0, 3'd3, 0, 0, 0, 0, "R8");

    // R9: loopback moves transmit samples, external arrivals ignored
    cyc(1, 0, 3'd0, 16'h0008, 0, 0, 0, "R9");
    for (int i = 0; i < 5; i++) cyc(1, 0, 3'd1, 16'hC000 + 16'(i), 1, 16'hDEAD, 1, "R9");
    for (int i = 0; i < 4; i++) cyc(0, 1, 3'd2, 0, 1, 16'hDEAD, 0, "R9");
    cyc(1, 0, 3'd0, 16'h0000, 0, 0, 0, "R9");

    // random traffic
    for (int it = 0; it < 4000; it++) begin
      int r = int'($urandom % 16);
      logic wr = 0, rd = 0;
      logic [2:0] a = 3'd3;
      logic [15:0] wd = 16'($urandom);
      if (r < 4)       begin wr = 1; a = 3'd1; end
      else if (r < 6)  begin rd = 1; a = 3'd2; end
      else if (r == 7) a = 3'd5;
      else if (r == 8) begin wr = 1; a = 3'd5; end
      else if (r == 9) begin
        wr = 1; a = 3'd0;
        wd[3] = ($urandom % 4 == 0);
        if ($urandom % 6 != 0) wd[2:0] = 3'b000;
      end
      else if (r == 10) begin wr = 1; a = 3'd4; end
      else if (r == 11) a = 3'd0;
      cyc(wr, rd, a, wd, 1'($urandom % 2), 16'($urandom), ($urandom % 4 == 0), tag_of(a));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule